// File: doc/BRIEF.md
# Column Pixel Clock Generator

This block drives the horizontal readout of one image-sensor row. On a row-start request it raises the column clock for a preset phase. Inside that phase it pulses the column sync line, which presets the column shift register to the loaded start position. It then steps the sensor through the programmed number of pixels. Every falling edge of the column clock selects the next pixel. The analog level ramps while the column clock is high and holds while it is low.

An ADC conversion clock is placed inside each low phase, so that each conversion edge falls while the analog level is settled. A data-valid strobe follows each conversion edge by a programmable number of cycles, which covers the converter's output delay. A one-cycle row-done flag closes the row.

All phase lengths are cycle counts. They are captured when the row starts, and values below the legal minimum are raised to that minimum. A parameter selects whether the outputs leave through a register stage.

Top module: `colclk_gen`

## Requirements
- R1: While reset is asserted and after its release, `col_clk`, `col_sync`, `adc_clk`, `data_valid` and `row_done` are all 0 until a row is accepted.
- R2: A `row_start` sampled high at clock edge 0, while idle and with `pix_count` >= 1, is accepted. The preset phase begins right after edge 0 when OUT_REG=0, or after edge 1 when OUT_REG=1. During the preset phase `col_clk` is high for `sync_len`+2 cycles and then falls. This fall selects the first pixel.
- R3: `col_sync` is high for exactly `sync_len` cycles, starting in the second cycle of the preset phase. It is high only while `col_clk` is high, and `col_clk` stays high for one cycle after it falls.
- R4: Each pixel has a low phase of `lo_len` cycles. Consecutive low phases are separated by high phases of `hi_len` cycles. A row has exactly `pix_count` falling edges of `col_clk`, and `col_clk` stays low after the last low phase.
- R5: `adc_clk` is high from the first cycle of each low phase up to, but not including, its last cycle. This gives exactly one falling edge per pixel, and it always occurs while `col_clk` is low. `adc_clk` is never high while `col_clk` is high.
- R6: `data_valid` is a one-cycle pulse, `dv_len` cycles after each falling edge of `adc_clk`.
- R7: `row_done` is high for exactly one cycle, in the cycle after the last low phase, with `col_clk` and `adc_clk` low.
- R8: A `row_start` that arrives while a row is in progress is ignored: the running row's output timing is unchanged and no second row follows.
- R9: A `row_start` with `pix_count` = 0 is ignored: no output toggles.
- R10: Programmed lengths are clamped when captured: `hi_len` 0 acts as 1, `lo_len` 0 or 1 acts as 2, `sync_len` 0 acts as 1, `dv_len` 0 acts as 1, and `dv_len` above DV_MAX acts as DV_MAX.
- R11: The count and length inputs are captured when a row is accepted. Changing them during the row has no effect on that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_start | input | 1 | Request to read out one row |
| pix_count | input | CW | Number of pixels in the row window |
| hi_len | input | TW | Column clock high-phase length in cycles |
| lo_len | input | TW | Column clock low-phase length in cycles |
| sync_len | input | TW | Column sync pulse length in cycles |
| dv_len | input | DVW | Delay from conversion edge to data-valid, in cycles |
| col_clk | output | 1 | Column pixel clock |
| col_sync | output | 1 | Column shift-register preset pulse |
| adc_clk | output | 1 | Conversion clock, falling edge samples the pixel |
| data_valid | output | 1 | Converter output valid strobe |
| row_done | output | 1 | One-cycle end-of-row flag |

## Verification
The bench predicts the cycle of every column-clock fall, sync edge, conversion fall, valid strobe and row-done pulse. It then matches the event stream one event at a time, so an off-by-one in any phase counter shows up as a cycle mismatch. A single-pixel row and a long row test the pixel count: a design that also counted the preset fall, or that raised the clock after the last pixel, would produce one falling edge too many or too few. Rows with zero or out-of-range lengths test the clamps, because an unclamped zero length would wrap the counter and stretch a phase to its full range. A second start, together with new input values, arrives in the middle of a row; a design that restarts the row or reads its inputs live would produce events the bench does not expect.

// File: rtl/xclk_pkg.sv
package xclk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_LOW  = 3'd2,
      ST_HIGH = 3'd3,
      ST_DONE = 3'd4
   } xclk_state_t;

   // bit positions of the output bundle passed to the output stage
   localparam int unsigned OB_COL  = 0;
   localparam int unsigned OB_SYNC = 1;
   localparam int unsigned OB_ADC  = 2;
   localparam int unsigned OB_DV   = 3;
   localparam int unsigned OB_DONE = 4;
   localparam int unsigned OB_W    = 5;

endpackage

// File: rtl/xclk_cfg_latch.sv
module xclk_cfg_latch #(
   parameter int unsigned CW     = 8,
   parameter int unsigned TW     = 5,
   parameter int unsigned DV_MAX = 6,
   parameter int unsigned DVW    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [CW-1:0]  pix_in,
   input  logic [TW-1:0]  hi_in,
   input  logic [TW-1:0]  lo_in,
   input  logic [TW-1:0]  sync_in,
   input  logic [DVW-1:0] dv_in,
   output logic [CW-1:0]  pix_q,
   output logic [TW-1:0]  hi_q,
   output logic [TW-1:0]  lo_q,
   output logic [TW-1:0]  sync_q,
   output logic [DVW-1:0] dv_q
);

   localparam logic [TW-1:0]  HI_MIN   = TW'(1);
   localparam logic [TW-1:0]  LO_MIN   = TW'(2);
   localparam logic [TW-1:0]  SYNC_MIN = TW'(1);
   localparam logic [DVW-1:0] DV_MIN   = DVW'(1);
   localparam logic [DVW-1:0] DV_TOP   = DVW'(DV_MAX);

   logic [TW-1:0]  hi_c, lo_c, sync_c;
   logic [DVW-1:0] dv_c;

   always_comb begin
      hi_c   = (hi_in   < HI_MIN)   ? HI_MIN   : hi_in;
      lo_c   = (lo_in   < LO_MIN)   ? LO_MIN   : lo_in;
      sync_c = (sync_in < SYNC_MIN) ? SYNC_MIN : sync_in;
      if (dv_in < DV_MIN)
         dv_c = DV_MIN;
      else if (dv_in > DV_TOP)
         dv_c = DV_TOP;
      else
         dv_c = dv_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q  <= CW'(1);
         hi_q   <= HI_MIN;
         lo_q   <= LO_MIN;
         sync_q <= SYNC_MIN;
         dv_q   <= DV_MIN;
      end else if (load) begin
         pix_q  <= pix_in;
         hi_q   <= hi_c;
         lo_q   <= lo_c;
         sync_q <= sync_c;
         dv_q   <= dv_c;
      end
   end

endmodule

// File: rtl/xclk_seq.sv
module xclk_seq
   import xclk_pkg::*;
#(
   parameter int unsigned CW = 8,
   parameter int unsigned TW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] pix_in,
   input  logic [CW-1:0] pix_q,
   input  logic [TW-1:0] hi_q,
   input  logic [TW-1:0] lo_q,
   input  logic [TW-1:0] sync_q,
   output logic          take,
   output logic          col_c,
   output logic          sync_c,
   output logic          adc_c,
   output logic          conv_ev,
   output logic          done_c
);

   localparam int unsigned CNTW = TW + 1;

   xclk_state_t      state;
   logic [CNTW-1:0]  cnt;
   logic [CW-1:0]    left;

   logic [CNTW-1:0]  pre_last, lo_last, hi_last;
   logic             pre_end, lo_end, hi_end;

   assign pre_last = CNTW'(sync_q) + CNTW'(1);
   assign lo_last  = CNTW'(lo_q) - CNTW'(1);
   assign hi_last  = CNTW'(hi_q) - CNTW'(1);

   assign pre_end  = (state == ST_PRE)  && (cnt == pre_last);
   assign lo_end   = (state == ST_LOW)  && (cnt == lo_last);
   assign hi_end   = (state == ST_HIGH) && (cnt == hi_last);

   assign take     = (state == ST_IDLE) && start && (pix_in != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         left  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (take) begin
                  state <= ST_PRE;
                  cnt   <= '0;
               end
            end
            ST_PRE: begin
               if (pre_end) begin
                  state <= ST_LOW;
                  cnt   <= '0;
                  left  <= pix_q;
               end else begin
                  cnt <= cnt + CNTW'(1);
               end
            end
            ST_LOW: begin
               if (lo_end) begin
                  state <= (left == CW'(1)) ? ST_DONE : ST_HIGH;
                  cnt   <= '0;
                  left  <= left - CW'(1);
               end else begin
                  cnt <= cnt + CNTW'(1);
               end
            end
            ST_HIGH: begin
               if (hi_end) begin
                  state <= ST_LOW;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNTW'(1);
               end
            end
            ST_DONE: begin
               state <= ST_IDLE;
               cnt   <= '0;
            end
            default: begin
               state <= ST_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // decode of the phase state into the raw output levels
   assign col_c   = (state == ST_PRE) || (state == ST_HIGH);
   assign sync_c  = (state == ST_PRE) && (cnt != '0) && (cnt <= CNTW'(sync_q));
   assign adc_c   = (state == ST_LOW) && (cnt < lo_last);
   assign conv_ev = lo_end;
   assign done_c  = (state == ST_DONE);

endmodule

// File: rtl/xclk_dv_delay.sv
module xclk_dv_delay #(
   parameter int unsigned DV_MAX = 6,
   parameter int unsigned DVW    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ev,
   input  logic [DVW-1:0] sel,
   output logic           dv
);

   logic [DV_MAX-1:0] sh;
   logic [DVW-1:0]    tap;

   for (genvar i = 0; i < DV_MAX; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= ev;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign tap = sel - DVW'(1);
   assign dv  = sh[tap];

endmodule

// File: rtl/xclk_outstage.sv
module xclk_outstage #(
   parameter int unsigned W       = 5,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (OUT_REG) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_wire
      assign q = d;
   end

endmodule

// File: rtl/colclk_gen.sv
module colclk_gen
   import xclk_pkg::*;
#(
   parameter int unsigned CW      = 8,
   parameter int unsigned TW      = 5,
   parameter int unsigned DV_MAX  = 6,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned DVW    = $clog2(DV_MAX + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           row_start,
   input  logic [CW-1:0]  pix_count,
   input  logic [TW-1:0]  hi_len,
   input  logic [TW-1:0]  lo_len,
   input  logic [TW-1:0]  sync_len,
   input  logic [DVW-1:0] dv_len,
   output logic           col_clk,
   output logic           col_sync,
   output logic           adc_clk,
   output logic           data_valid,
   output logic           row_done
);

   if (CW < 1) begin : g_bad_cw
      $error("colclk_gen: CW must be at least 1");
   end
   if (TW < 2) begin : g_bad_tw
      $error("colclk_gen: TW must be at least 2 to hold the low-phase minimum");
   end
   if (DV_MAX < 1) begin : g_bad_dv
      $error("colclk_gen: DV_MAX must be at least 1");
   end

   logic           take;
   logic [CW-1:0]  pix_q;
   logic [TW-1:0]  hi_q, lo_q, sync_q;
   logic [DVW-1:0] dv_q;
   logic           col_c, sync_c, adc_c, conv_ev, done_c, dv_c;
   logic [OB_W-1:0] raw, outq;

   xclk_cfg_latch #(.CW(CW), .TW(TW), .DV_MAX(DV_MAX), .DVW(DVW)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (take),
      .pix_in  (pix_count),
      .hi_in   (hi_len),
      .lo_in   (lo_len),
      .sync_in (sync_len),
      .dv_in   (dv_len),
      .pix_q   (pix_q),
      .hi_q    (hi_q),
      .lo_q    (lo_q),
      .sync_q  (sync_q),
      .dv_q    (dv_q)
   );

   xclk_seq #(.CW(CW), .TW(TW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (row_start),
      .pix_in  (pix_count),
      .pix_q   (pix_q),
      .hi_q    (hi_q),
      .lo_q    (lo_q),
      .sync_q  (sync_q),
      .take    (take),
      .col_c   (col_c),
      .sync_c  (sync_c),
      .adc_c   (adc_c),
      .conv_ev (conv_ev),
      .done_c  (done_c)
   );

   xclk_dv_delay #(.DV_MAX(DV_MAX), .DVW(DVW)) u_dv (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (conv_ev),
      .sel   (dv_q),
      .dv    (dv_c)
   );

   always_comb begin
      raw          = '0;
      raw[OB_COL]  = col_c;
      raw[OB_SYNC] = sync_c;
      raw[OB_ADC]  = adc_c;
      raw[OB_DV]   = dv_c;
      raw[OB_DONE] = done_c;
   end

   xclk_outstage #(.W(OB_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (outq)
   );

   assign col_clk    = outq[OB_COL];
   assign col_sync   = outq[OB_SYNC];
   assign adc_clk    = outq[OB_ADC];
   assign data_valid = outq[OB_DV];
   assign row_done   = outq[OB_DONE];

endmodule

// File: rtl/colclk_gen_chk.sv
module colclk_gen_chk #(
   parameter int unsigned CW = 8
) (
   input logic clk,
   input logic rst_n,
   input logic col_clk,
   input logic col_sync,
   input logic adc_clk,
   input logic row_done
);

   localparam int unsigned NW = CW + 1;

   logic          col_prev, adc_prev;
   logic [NW-1:0] col_falls, adc_falls;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_prev  <= 1'b0;
         adc_prev  <= 1'b0;
         col_falls <= '0;
         adc_falls <= '0;
      end else begin
         col_prev <= col_clk;
         adc_prev <= adc_clk;
         if (row_done) begin
            col_falls <= '0;
            adc_falls <= '0;
         end else begin
            if (col_prev && !col_clk) col_falls <= col_falls + NW'(1);
            if (adc_prev && !adc_clk) adc_falls <= adc_falls + NW'(1);
         end
      end
   end

   // R3: sync only inside a high phase of the column clock
   assert_sync_in_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      col_sync |-> col_clk);

   // R3: sync rises only after the column clock has already been high
   assert_sync_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(col_sync) |-> $past(col_clk));

   // R3: column clock still high in the cycle sync drops
   assert_sync_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(col_sync) |-> col_clk);

   // R5: conversion clock never high in a high phase
   assert_adc_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      adc_clk |-> !col_clk);

   // R7: row-done lasts a single cycle
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      row_done |=> !row_done);

   // R7: row-done comes with both clocks low
   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      row_done |-> (!col_clk && !adc_clk));

   // R4, R5: one conversion edge per column clock fall in a completed row
   assert_fall_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      row_done |-> ((col_falls == adc_falls) && (col_falls != '0)));

endmodule

bind colclk_gen colclk_gen_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .col_clk  (col_clk),
   .col_sync (col_sync),
   .adc_clk  (adc_clk),
   .row_done (row_done)
);

// File: tb/sim_colclk_gen.sv
module sim_colclk_gen;

   localparam int unsigned CW      = 8;
   localparam int unsigned TW      = 5;
   localparam int unsigned DV_MAX  = 6;
   localparam bit          OUT_REG = 1'b1;
   localparam int unsigned DVW     = $clog2(DV_MAX + 1);
   localparam int          LAT     = OUT_REG ? 1 : 0;

   // event kinds, in the order the monitor examines them within a cycle
   localparam logic [3:0] K_COLF  = 4'd0;
   localparam logic [3:0] K_SYNR  = 4'd1;
   localparam logic [3:0] K_SYNF  = 4'd2;
   localparam logic [3:0] K_ADCF  = 4'd3;
   localparam logic [3:0] K_DV    = 4'd4;
   localparam logic [3:0] K_DONE  = 4'd5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           row_start = 1'b0;
   logic [CW-1:0]  pix_count = '0;
   logic [TW-1:0]  hi_len = '0;
   logic [TW-1:0]  lo_len = '0;
   logic [TW-1:0]  sync_len = '0;
   logic [DVW-1:0] dv_len = '0;
   logic           col_clk, col_sync, adc_clk, data_valid, row_done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [35:0] expq[$];

   always #10 clk = ~clk;   // 50 MHz

   always @(posedge clk) cyc <= cyc + 1;

   colclk_gen #(.CW(CW), .TW(TW), .DV_MAX(DV_MAX), .OUT_REG(OUT_REG)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_start  (row_start),
      .pix_count  (pix_count),
      .hi_len     (hi_len),
      .lo_len     (lo_len),
      .sync_len   (sync_len),
      .dv_len     (dv_len),
      .col_clk    (col_clk),
      .col_sync   (col_sync),
      .adc_clk    (adc_clk),
      .data_valid (data_valid),
      .row_done   (row_done)
   );

   function automatic string kind_req(logic [3:0] k);
      case (k)
         K_COLF:  return "R4 column clock fall";
         K_SYNR:  return "R3 sync rise";
         K_SYNF:  return "R3 sync fall";
         K_ADCF:  return "R5 conversion fall";
         K_DV:    return "R6 data valid";
         K_DONE:  return "R7 row done";
         default: return "R2 unknown";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_ev(input int c, input logic [3:0] k);
      expq.push_back({c[31:0], k});
   endtask

   // monitor: compares observed edges with the scoreboard queue
   logic p_col = 1'b0, p_sync = 1'b0, p_adc = 1'b0;

   task automatic match(input logic [3:0] k);
      logic [35:0] e;
      if (expq.size() == 0) begin
         checks++;
         errors++;
         $display("FAIL %s unexpected: actual cycle=%0d expected=none", kind_req(k), cyc);
      end else begin
         e = expq.pop_front();
         check(e == {cyc[31:0], k}, kind_req(k), longint'(cyc) * 16 + k, longint'(e));
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_col && !col_clk)    match(K_COLF);
         if (!p_sync && col_sync)  match(K_SYNR);
         if (p_sync && !col_sync)  match(K_SYNF);
         if (p_adc && !adc_clk)    match(K_ADCF);
         if (data_valid)           match(K_DV);
         if (row_done)             match(K_DONE);
      end
      p_col  <= col_clk;
      p_sync <= col_sync;
      p_adc  <= adc_clk;
   end

   // driver: predicts the events of one row from the requirements
   task automatic run_row(input int n, input int hi, input int lo, input int sy,
                          input int dv, input bit disturb);
      int eh, el, es, ed, s, base, pre, lk;
      eh = (hi < 1) ? 1 : hi;                        // R10 clamps
      el = (lo < 2) ? 2 : lo;
      es = (sy < 1) ? 1 : sy;
      ed = (dv < 1) ? 1 : ((dv > DV_MAX) ? DV_MAX : dv);
      @(negedge clk);
      pix_count = CW'(n);
      hi_len    = TW'(hi);
      lo_len    = TW'(lo);
      sync_len  = TW'(sy);
      dv_len    = DVW'(dv);
      s    = cyc + 1;
      base = s + LAT;
      pre  = es + 2;                                 // R2 preset length
      if (n > 0) begin
         push_ev(base + 1, K_SYNR);
         push_ev(base + es + 1, K_SYNF);
         push_ev(base + pre, K_COLF);
         for (int k = 0; k < n; k++) begin
            lk = base + pre + k * (el + eh);
            if (k > 0) push_ev(lk, K_COLF);
            push_ev(lk + el - 1, K_ADCF);
            push_ev(lk + el - 1 + ed, K_DV);
            if (k == n - 1) push_ev(lk + el, K_DONE);
         end
         expq.sort();
      end
      row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      if (disturb) begin
         // R8, R11: second start and new settings while the row runs
         repeat (5) @(negedge clk);
         pix_count = CW'(2);
         hi_len    = TW'(9);
         lo_len    = TW'(11);
         sync_len  = TW'(4);
         dv_len    = DVW'(2);
         row_start = 1'b1;
         @(negedge clk);
         row_start = 1'b0;
      end
      if (n > 0) begin
         for (int i = 0; i < 4000 && expq.size() != 0; i++) @(negedge clk);
         repeat (DV_MAX + 4) @(negedge clk);
      end else begin
         repeat (20) @(negedge clk);
         // R9: ignored start leaves the clock idle
         check(col_clk == 1'b0, "R9 col_clk after zero-count start", col_clk, 0);
      end
      check(expq.size() == 0, "R4 all predicted events seen", expq.size(), 0);
      check(col_clk == 1'b0, "R4 col_clk low after row", col_clk, 0);
      expq.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check({col_clk, col_sync, adc_clk, data_valid, row_done} == 5'b0,
            "R1 outputs in reset", {col_clk, col_sync, adc_clk, data_valid, row_done}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check({col_clk, col_sync, adc_clk, data_valid, row_done} == 5'b0,
            "R1 outputs after reset", {col_clk, col_sync, adc_clk, data_valid, row_done}, 0);

      run_row(4, 3, 4, 2, 2, 1'b0);      // R2 R4 R5 R6 R7 basic row
      run_row(1, 2, 3, 1, 1, 1'b0);      // R4 single pixel
      run_row(12, 1, 2, 3, 6, 1'b0);     // R6 longest delay, tight phases
      run_row(5, 6, 7, 5, 3, 1'b1);      // R8 R11 disturbed row
      run_row(0, 3, 3, 2, 2, 1'b0);      // R9 zero count
      run_row(3, 0, 1, 0, 0, 1'b0);      // R10 low clamps
      run_row(3, 2, 5, 2, 7, 1'b0);      // R10 dv above DV_MAX
      run_row(20, 4, 9, 8, 4, 1'b0);     // R4 long row

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule